// File: doc/BRIEF.md
# Host Bridge Control Register Bank

This block is the control and status register bank of a host bridge. It sits on a simple word-wide register bus. A requester presents a byte address, a write strobe and write data. The block returns read data in the same cycle, drawn from the addressed word. The bank spans 28 words, 0x70 bytes in all. Most of these words are plain configuration storage: bridge power-up and general settings, IO device and SDRAM setup, PCI mapping, GPIO data and enables, interrupt edge, steering and polarity, four mailboxes, cache control, timing, and memory size. The block does not act on these values. They are handed on to the rest of the chip.

Two words need special handling. The interrupt enable word cannot be written directly. It is raised through a write-one-to-set alias and lowered through a write-one-to-clear alias, and each alias also keeps the last value written to it. A bit in the general configuration word acts as a software reset trigger. When a write takes that bit from 0 to 1, the block emits a one-cycle reset request pulse.

Top module: `bridge_ctrl_regs`

## Requirements
- R1: After synchronous reset, the words hold these values (byte offset = value): 0x00=0x00000C40, 0x04=0x00001384, 0x08=0x2BFF8010, 0x0C=0x255E0091, 0x10=0x00006140, 0x1C=0x000001FF, 0x20=0x000001FF, 0x68=0x00000008, 0x6C=0x10000000. Every other offset from 0x00 to 0x6C reads zero.
- R2: A write to any offset from 0x00 to 0x6C, except 0x38 and 0x3C, stores the full 32-bit value, and later reads of that offset return it.
- R3: An access decodes only when address bits [1:0] are zero and the byte address is below 0x70. Any other write changes nothing, and any other read returns zero.
- R4: A write to 0x30 stores the value at 0x30 and ORs it into the enable word at 0x38.
- R5: A write to 0x34 stores the value at 0x34 and clears, in the enable word at 0x38, every bit written as one.
- R6: The enable word (0x38) changes only through writes to 0x30 and 0x34, and direct writes to 0x38 are ignored. The status word (0x3C) ignores writes and always reads zero.
- R7: A write to 0x04 whose bit 2 is 1, while the stored bit 2 is 0, stores the value and raises rst_req for exactly the one cycle after the write edge.
- R8: rst_req stays low for writes to 0x04 while the stored bit 2 is already 1, and for writes to any other offset.
- R9: bus_rdata follows bus_addr combinationally, and a write is visible on reads in the cycle after its clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_we | input | 1 | Write strobe, one word per cycle |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr, zero when not decoded |
| rst_req | output | 1 | One-cycle software reset request |

## Verification
The bench builds the block with ADDR_W=8, DATA_W=32 and RST_BIT=2. With an 8-bit address, the random stream reaches aligned offsets above the 0x70 window as well as every misaligned address, so the ignore-and-read-zero paths are exercised alongside the decoded words. Keeping the trigger at bit 2 lets directed writes start from the reset value 0x1384, where that bit is already set, and then walk the bit through clear, rise and repeat.

// File: rtl/brc_pkg.sv
// Package: layout constants and reset values of the bridge control bank.
// Assumes 32-bit words and a bank of 28 words at consecutive word offsets.
package brc_pkg;

    localparam int WORD_BYTES = 4;
    localparam int NUM_WORDS  = 28;
    localparam int WIN_BYTES  = NUM_WORDS * WORD_BYTES;

    // Word indexes with special behaviour
    localparam int IDX_GEN    = 1;
    localparam int IDX_EN_SET = 12;
    localparam int IDX_EN_CLR = 13;
    localparam int IDX_EN     = 14;
    localparam int IDX_STAT   = 15;

    typedef enum logic [1:0] {
        WK_STORE = 2'd0,
        WK_SET   = 2'd1,
        WK_CLR   = 2'd2,
        WK_RO    = 2'd3
    } word_kind_e;

    // Kind of a word index: plain storage, alias, or read-only
    function automatic word_kind_e word_kind(input int idx);
        if (idx == IDX_EN_SET)                  return WK_SET;
        else if (idx == IDX_EN_CLR)             return WK_CLR;
        else if (idx == IDX_EN || idx == IDX_STAT) return WK_RO;
        else                                    return WK_STORE;
    endfunction

    // Reset value of a word index
    function automatic logic [31:0] reset_word(input int idx);
        case (idx)
            0:       return 32'h0000_0C40;
            1:       return 32'h0000_1384;
            2:       return 32'h2BFF_8010;
            3:       return 32'h255E_0091;
            4:       return 32'h0000_6140;
            7:       return 32'h0000_01FF;
            8:       return 32'h0000_01FF;
            26:      return 32'h0000_0008;
            27:      return 32'h1000_0000;
            default: return 32'h0000_0000;
        endcase
    endfunction

endpackage

// File: rtl/brc_decode.sv
// Address decoder: turns a byte address into a word index and a hit flag.
// Assumes ADDR_W is wide enough to hold the window size; misaligned
// addresses and addresses at or beyond the window do not hit.
module brc_decode #(
    parameter int ADDR_W    = 8,
    parameter int NUM_WORDS = brc_pkg::NUM_WORDS,
    localparam int IDX_W    = $clog2(NUM_WORDS)
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [IDX_W-1:0]  idx
);
    localparam logic [ADDR_W-1:0] WIN_LIM = ADDR_W'(NUM_WORDS * brc_pkg::WORD_BYTES);

    // Decode alignment and range of the access
    always_comb begin
        hit = (addr[1:0] == 2'b00) && (addr < WIN_LIM);
        idx = addr[IDX_W+1:2];
    end
endmodule

// File: rtl/brc_word_bank.sv
// Word bank: one register per word index, written whole when selected.
// Assumes the read-only indexes are supplied elsewhere; they read as zero here.
module brc_word_bank #(
    parameter int DATA_W    = 32,
    parameter int NUM_WORDS = brc_pkg::NUM_WORDS,
    localparam int IDX_W    = $clog2(NUM_WORDS)
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_en,
    input  logic [IDX_W-1:0]                  wr_idx,
    input  logic [DATA_W-1:0]                 wr_data,
    output logic [NUM_WORDS-1:0][DATA_W-1:0]  words
);
    for (genvar g = 0; g < NUM_WORDS; g++) begin : g_word
        if (brc_pkg::word_kind(g) == brc_pkg::WK_RO) begin : g_ro
            assign words[g] = '0;
        end else begin : g_rw
            localparam logic [DATA_W-1:0] RST_VAL = DATA_W'(brc_pkg::reset_word(g));
            // Hold the word, load it on a selected write
            always_ff @(posedge clk) begin
                if (!rst_n)
                    words[g] <= RST_VAL;
                else if (wr_en && (wr_idx == IDX_W'(g)))
                    words[g] <= wr_data;
            end
        end
    end
endmodule

// File: rtl/brc_irq_enable.sv
// Interrupt enable word: bits raised by the set alias, lowered by the clear alias.
// Assumes at most one of set_we and clr_we is high in a cycle.
module brc_irq_enable #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_we,
    input  logic              clr_we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] en_q
);
    // Update the enable bits from the alias writes
    always_ff @(posedge clk) begin
        if (!rst_n)
            en_q <= '0;
        else if (set_we)
            en_q <= en_q | wdata;
        else if (clr_we)
            en_q <= en_q & ~wdata;
    end
endmodule

// File: rtl/brc_reset_pulse.sv
// Reset request generator: one-cycle pulse when a general-config write
// raises the trigger bit. Assumes old_bit is the stored bit before the write.
module brc_reset_pulse (
    input  logic clk,
    input  logic rst_n,
    input  logic gen_we,
    input  logic old_bit,
    input  logic new_bit,
    output logic rst_req
);
    // Register the rising-trigger condition for one cycle
    always_ff @(posedge clk) begin
        if (!rst_n)
            rst_req <= 1'b0;
        else
            rst_req <= gen_we && !old_bit && new_bit;
    end
endmodule

// File: rtl/bridge_ctrl_regs.sv
// Top: host bridge control register bank on a simple word bus.
// Reads are combinational; writes take effect at the clock edge.
// Assumes one access per cycle and full-word accesses only.
module bridge_ctrl_regs #(
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 32,
    parameter int RST_BIT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              rst_req
);
    import brc_pkg::*;

    localparam int IDX_W = $clog2(NUM_WORDS);
    localparam logic [IDX_W-1:0] I_GEN  = IDX_W'(IDX_GEN);
    localparam logic [IDX_W-1:0] I_SET  = IDX_W'(IDX_EN_SET);
    localparam logic [IDX_W-1:0] I_CLR  = IDX_W'(IDX_EN_CLR);
    localparam logic [IDX_W-1:0] I_EN   = IDX_W'(IDX_EN);

    logic                             hit;
    logic [IDX_W-1:0]                 idx;
    logic                             wr_hit;
    logic [NUM_WORDS-1:0][DATA_W-1:0] words;
    logic [DATA_W-1:0]                en_q;
    logic                             gen_rst_bit;

    brc_decode #(.ADDR_W(ADDR_W), .NUM_WORDS(NUM_WORDS)) u_dec (
        .addr (bus_addr),
        .hit  (hit),
        .idx  (idx)
    );

    assign wr_hit      = bus_we && hit;
    assign gen_rst_bit = words[IDX_GEN][RST_BIT];

    brc_word_bank #(.DATA_W(DATA_W), .NUM_WORDS(NUM_WORDS)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_hit),
        .wr_idx  (idx),
        .wr_data (bus_wdata),
        .words   (words)
    );

    brc_irq_enable #(.DATA_W(DATA_W)) u_en (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_we (wr_hit && (idx == I_SET)),
        .clr_we (wr_hit && (idx == I_CLR)),
        .wdata  (bus_wdata),
        .en_q   (en_q)
    );

    brc_reset_pulse u_rst (
        .clk     (clk),
        .rst_n   (rst_n),
        .gen_we  (wr_hit && (idx == I_GEN)),
        .old_bit (gen_rst_bit),
        .new_bit (bus_wdata[RST_BIT]),
        .rst_req (rst_req)
    );

    // Select the read word; undecoded accesses return zero
    always_comb begin
        bus_rdata = '0;
        if (hit) begin
            if (idx == I_EN)
                bus_rdata = en_q;
            else
                bus_rdata = words[idx];
        end
    end
endmodule

// File: rtl/brc_checker.sv
// Checker: temporal properties of the bridge control bank, bound to the top.
module brc_checker #(
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 32,
    parameter int RST_BIT = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              rst_req,
    input logic [DATA_W-1:0] en_q,
    input logic              gen_bit
);
    localparam logic [ADDR_W-1:0] A_GEN  = ADDR_W'(8'h04);
    localparam logic [ADDR_W-1:0] A_SET  = ADDR_W'(8'h30);
    localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(8'h34);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(8'h3C);
    localparam logic [ADDR_W-1:0] A_LIM  = ADDR_W'(8'h70);

    logic wr_set, wr_clr, wr_gen, undec;
    assign wr_set = bus_we && (bus_addr == A_SET);
    assign wr_clr = bus_we && (bus_addr == A_CLR);
    assign wr_gen = bus_we && (bus_addr == A_GEN);
    assign undec  = (bus_addr[1:0] != 2'b00) || (bus_addr >= A_LIM);

    AST_UNDEC_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        undec |-> (bus_rdata == '0)); // R3
    AST_ENSET_OR: assert property (@(posedge clk) disable iff (!rst_n)
        wr_set |=> (en_q == ($past(en_q) | $past(bus_wdata)))); // R4
    AST_ENCLR_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        wr_clr |=> (en_q == ($past(en_q) & ~$past(bus_wdata)))); // R5
    AST_EN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_set || wr_clr) |=> $stable(en_q)); // R6
    AST_STAT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == A_STAT) |-> (bus_rdata == '0)); // R6
    AST_RST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req); // R7
    AST_RST_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_req) |-> $past(wr_gen && bus_wdata[RST_BIT] && !gen_bit)); // R7
    AST_RST_NO_REPEAT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_gen && gen_bit) |=> !rst_req); // R8
endmodule

bind bridge_ctrl_regs brc_checker #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .RST_BIT(RST_BIT)
) u_brc_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .rst_req   (rst_req),
    .en_q      (en_q),
    .gen_bit   (gen_rst_bit)
);

// File: tb/bridge_ctrl_regs_bench.sv
// Bench: directed corner cases plus seeded random traffic against a model.
module bridge_ctrl_regs_bench;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;
    localparam int RST_BIT = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic              bus_we = 1'b0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic [DATA_W-1:0] bus_rdata;
    logic              rst_req;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [31:0] mdl [28];
    logic [31:0] mdl_en;

    always #(CLK_PERIOD/2) clk = ~clk;

    bridge_ctrl_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .RST_BIT(RST_BIT)) u_bridge_ctrl_regs (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rst_req(rst_req)
    );

    function automatic logic [31:0] rst_val(input int i);
        case (i)
            0: return 32'h0000_0C40;
            1: return 32'h0000_1384;
            2: return 32'h2BFF_8010;
            3: return 32'h255E_0091;
            4: return 32'h0000_6140;
            7: return 32'h0000_01FF;
            8: return 32'h0000_01FF;
            26: return 32'h0000_0008;
            27: return 32'h1000_0000;
            default: return 32'h0;
        endcase
    endfunction

    function automatic bit decoded(input logic [7:0] a);
        return (a[1:0] == 2'b00) && (a < 8'h70);
    endfunction

    function automatic logic [31:0] exp_read(input logic [7:0] a);
        if (!decoded(a)) return 32'h0;
        if (a == 8'h38) return mdl_en;
        if (a == 8'h3C) return 32'h0;
        return mdl[a[6:2]];
    endfunction

    function automatic string tag_of(input logic [7:0] a);
        if (!decoded(a)) return "R3";
        if (a == 8'h30) return "R4";
        if (a == 8'h34) return "R5";
        if (a == 8'h38 || a == 8'h3C) return "R6";
        return "R2";
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    // Read one address and compare with the model
    task automatic do_read(input logic [7:0] a, input string tag);
        @(negedge clk);
        bus_we = 1'b0;
        bus_addr = a;
        #1;
        check(tag, bus_rdata, exp_read(a));
    endtask

    // Write one word, update the model, check the reset request pulse
    task automatic do_write(input logic [7:0] a, input logic [31:0] d);
        bit pulse;
        @(negedge clk);
        bus_we = 1'b1;
        bus_addr = a;
        bus_wdata = d;
        pulse = 0;
        if (decoded(a) && a != 8'h38 && a != 8'h3C) begin
            if (a == 8'h04) pulse = !mdl[1][RST_BIT] && d[RST_BIT];
            mdl[a[6:2]] = d;
            if (a == 8'h30) mdl_en = mdl_en | d;
            if (a == 8'h34) mdl_en = mdl_en & ~d;
        end
        @(negedge clk);
        bus_we = 1'b0;
        check(pulse ? "R7" : "R8", {31'b0, rst_req}, {31'b0, pulse});
    endtask

    initial begin
        for (int i = 0; i < 28; i++) mdl[i] = rst_val(i);
        mdl_en = 32'h0;
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check("R7", {31'b0, rst_req}, 32'h0);
        // R1: reset values of the whole window
        for (int i = 0; i < 28; i++) do_read(8'(i * 4), "R1");
        // R9: write visible on the next cycle
        do_write(8'h40, 32'hA5A5_1234);
        do_read(8'h40, "R9");
        // R4 / R5 / R6: enable aliases and read-only words
        do_write(8'h30, 32'h0000_00F0);
        do_read(8'h38, "R4");
        do_write(8'h30, 32'h0000_000F);
        do_read(8'h38, "R4");
        do_read(8'h30, "R4");
        do_write(8'h34, 32'h0000_003C);
        do_read(8'h38, "R5");
        do_read(8'h34, "R5");
        do_write(8'h38, 32'hFFFF_FFFF);
        do_read(8'h38, "R6");
        do_write(8'h3C, 32'hFFFF_FFFF);
        do_read(8'h3C, "R6");
        // R8 / R7: trigger bit starts at 1 after reset
        do_write(8'h04, 32'h0000_0004);
        do_write(8'h04, 32'h0000_0000);
        do_write(8'h04, 32'h0000_1384);
        do_write(8'h04, 32'h0000_0004);
        do_write(8'h00, 32'h0000_0004);
        do_read(8'h04, "R7");
        // R3: misaligned and out-of-window accesses
        do_write(8'h41, 32'h1111_1111);
        do_read(8'h40, "R3");
        do_read(8'h41, "R3");
        do_write(8'h80, 32'h2222_2222);
        do_read(8'h80, "R3");
        do_read(8'h70, "R3");
        // R2: random traffic
        for (int n = 0; n < 600; n++) begin
            int r;
            logic [7:0] a;
            r = int'($urandom % 10);
            if (r < 7)       a = 8'(($urandom % 28) * 4);
            else if (r == 7) a = 8'(8'h70 + ($urandom % 36) * 4);
            else begin
                a = 8'($urandom % 256);
                if (a[1:0] == 2'b00) a[0] = 1'b1;
            end
            if ($urandom % 5 == 0) a = 8'h04;
            if ($urandom % 2 == 0) do_write(a, $urandom);
            else do_read(a, tag_of(a));
        end
        for (int i = 0; i < 28; i++) do_read(8'(i * 4), tag_of(8'(i * 4)));
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule